// File: doc/BRIEF.md
# Serial Clock-Synthesizer Programming Sequencer

This block loads a frequency setting into an external clock synthesizer that takes its configuration one bit at a time through a bit-banged control register. A single start pulse makes it save the present control value, clear the register, ask the display pipeline to blank, and wait for the output to settle. It then sends a short wake-up preamble and a 21-bit serial frame. The frame holds a fixed marker, a start bit, a write-select bit, a 5-bit location address and a 13-bit program word.

Each serial bit is sent as two register updates. The first puts the data value on the register with the serial clock low. The second raises the serial clock. After every update a strobe pulse latches the register into the synthesizer, and a settle wait always comes before that strobe. After the frame the sequencer waits, lifts the blank request, and restores the saved control value with the latch flag set. After a long final wait it selects the newly programmed location and reports completion. Every wait is a parameter in clock cycles. Computing the program word is left to the caller.

Top module: `synth_serial_loader`

## Requirements
- R1: After reset, `ctl_o` is 0x00 and `strobe_o`, `blank_o`, `done_o` and `busy_o` are all 0.
- R2: A start while idle sets `blank_o` and `busy_o` and clears `ctl_o` to 0x00 on the next clock. The first strobe comes no sooner than BLANK_CYC + SETTLE_CYC − 1 cycles after that clock.
- R3: The first two strobes of a run see `ctl_o` equal to 0x00 and then 0x01.
- R4: The serial frame is 21 bits, carried on `ctl_o` bit 2. In order they are: 1, 0, 0, then `loc_i` bits 0 to 4, then `word_i` bits 0 to 12.
- R5: Each frame bit gets two strobes. At the first, `ctl_o` bit 3 is 0. At the second, bit 3 is 1. Every other bit keeps the value left by the preamble, so the strobed values are 0x01|d<<2 and then 0x09|d<<2.
- R6: At every strobe, `ctl_o` has held its value for at least SETTLE_CYC cycles, counting the strobe cycle.
- R7: When `blank_o` falls after the frame, `ctl_o` equals the value saved at start with bit 6 set.
- R8: After the final wait, `ctl_o` becomes 0x40 | `loc_i`[3:0], and `done_o` pulses for one cycle while `busy_o` and `blank_o` are low.
- R9: A start while busy is ignored. The strobed values, restore value and final value of the current run are unchanged.
- R10: The value saved at start is the control value at that time. A second run therefore restores the first run's final value with bit 6 set.
- R11: `strobe_o` is only high while `blank_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a programming run (idle only) |
| loc_i | input | 5 | Synthesizer location address |
| word_i | input | 13 | Program word to load |
| ctl_o | output | 8 | Clock control register value |
| strobe_o | output | 1 | Latch pulse for the control register |
| blank_o | output | 1 | Display blank request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with SETTLE_CYC = 3, BLANK_CYC = 20, TAIL_CYC = 8 and FINAL_CYC = 12, in place of delays that span millions of cycles. With these values several complete runs fit in a few hundred cycles. They include back-to-back runs, which show that the saved value carries over, and a start pulse in the middle of a frame. A settle of 3 still leaves a window in which a strobe issued too early would show up against the hold count.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  localparam int unsigned CTL_W    = 8;
  localparam int unsigned DATA_BIT = 2;
  localparam int unsigned SCLK_BIT = 3;
  localparam int unsigned FLAG_BIT = 6;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned WORD_W   = 13;
  localparam int unsigned PRE_W    = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_BLANK, S_PRE0, S_PRE1, S_BITLO, S_BITHI, S_TAIL, S_FINAL
  } seq_state_t;
endpackage

// File: rtl/ssl_delay_timer.sv
module ssl_delay_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ssl_frame_shifter.sv
module ssl_frame_shifter #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  output logic              head_o,
  output logic              next_o,
  output logic              last_o
);
  localparam int unsigned FRAME_W = 3 + ADDR_W + WORD_W;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               sh_en;

  always_comb begin
    sh_en = load_i || shift_i;
    if (load_i) begin
      sh_d  = {word_i, addr_i, 3'b001};
      idx_d = '0;
    end else begin
      sh_d  = {1'b0, sh_q[FRAME_W-1:1]};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign head_o = sh_q[0];
  assign next_o = sh_q[1];
  assign last_o = (idx_q == IDX_W'(FRAME_W - 1));
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
  parameter int unsigned SETTLE_CYC = 1300,
  parameter int unsigned BLANK_CYC  = 750000,
  parameter int unsigned TAIL_CYC   = 50000,
  parameter int unsigned FINAL_CYC  = 2500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [4:0]  loc_i,
  input  logic [12:0] word_i,
  output logic [7:0]  ctl_o,
  output logic        strobe_o,
  output logic        blank_o,
  output logic        busy_o,
  output logic        done_o
);
  import ssl_pkg::*;

  localparam int unsigned MAX_AB = (SETTLE_CYC > BLANK_CYC) ? SETTLE_CYC : BLANK_CYC;
  localparam int unsigned MAX_CD = (TAIL_CYC > FINAL_CYC) ? TAIL_CYC : FINAL_CYC;
  localparam int unsigned MAX_D  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W  = $clog2(MAX_D + 1);
  localparam logic [CNT_W-1:0] SET_V = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] BLK_V = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] TL_V  = CNT_W'(TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] FN_V  = CNT_W'(FINAL_CYC - 1);

  seq_state_t       st_q, st_d;
  logic [CTL_W-1:0] ctl_q, ctl_d, save_q, save_d;
  logic [ADDR_W-1:0] loc_q, loc_d;
  logic             blank_q, blank_d, done_q, done_d;
  logic             tm_load, tm_exp;
  logic [CNT_W-1:0] tm_val;
  logic             sh_load, sh_shift, sh_head, sh_next, sh_last;
  logic             in_strobe_state;

  ssl_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tm_load), .val_i(tm_val), .expired_o(tm_exp)
  );

  ssl_frame_shifter #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(sh_load), .addr_i(loc_i), .word_i(word_i),
    .shift_i(sh_shift), .head_o(sh_head), .next_o(sh_next), .last_o(sh_last)
  );

  always_comb begin
    st_d     = st_q;
    ctl_d    = ctl_q;
    save_d   = save_q;
    loc_d    = loc_q;
    blank_d  = blank_q;
    done_d   = 1'b0;
    tm_load  = 1'b0;
    tm_val   = SET_V;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        save_d  = ctl_q;
        loc_d   = loc_i;
        ctl_d   = '0;
        blank_d = 1'b1;
        sh_load = 1'b1;
        tm_load = 1'b1;
        tm_val  = BLK_V;
        st_d    = S_BLANK;
      end
      S_BLANK: if (tm_exp) begin
        ctl_d   = '0;
        tm_load = 1'b1;
        st_d    = S_PRE0;
      end
      S_PRE0: if (tm_exp) begin
        ctl_d   = CTL_W'(1);
        tm_load = 1'b1;
        st_d    = S_PRE1;
      end
      S_PRE1: if (tm_exp) begin
        ctl_d[DATA_BIT] = sh_head;
        ctl_d[SCLK_BIT] = 1'b0;
        tm_load = 1'b1;
        st_d    = S_BITLO;
      end
      S_BITLO: if (tm_exp) begin
        ctl_d[SCLK_BIT] = 1'b1;
        tm_load = 1'b1;
        st_d    = S_BITHI;
      end
      S_BITHI: if (tm_exp) begin
        tm_load = 1'b1;
        if (sh_last) begin
          tm_val = TL_V;
          st_d   = S_TAIL;
        end else begin
          sh_shift        = 1'b1;
          ctl_d[DATA_BIT] = sh_next;
          ctl_d[SCLK_BIT] = 1'b0;
          st_d            = S_BITLO;
        end
      end
      S_TAIL: if (tm_exp) begin
        blank_d         = 1'b0;
        ctl_d           = save_q;
        ctl_d[FLAG_BIT] = 1'b1;
        tm_load         = 1'b1;
        tm_val          = FN_V;
        st_d            = S_FINAL;
      end
      S_FINAL: if (tm_exp) begin
        ctl_d           = '0;
        ctl_d[3:0]      = loc_q[3:0];
        ctl_d[FLAG_BIT] = 1'b1;
        done_d          = 1'b1;
        st_d            = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      ctl_q   <= '0;
      save_q  <= '0;
      loc_q   <= '0;
      blank_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ctl_q   <= ctl_d;
      save_q  <= save_d;
      loc_q   <= loc_d;
      blank_q <= blank_d;
      done_q  <= done_d;
    end
  end

  assign in_strobe_state = (st_q == S_PRE0) || (st_q == S_PRE1) ||
                           (st_q == S_BITLO) || (st_q == S_BITHI);
  assign strobe_o = in_strobe_state && tm_exp;
  assign ctl_o    = ctl_q;
  assign blank_o  = blank_q;
  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = done_q;
endmodule

// File: rtl/ssl_checker.sv
module ssl_checker #(
  parameter int unsigned SETTLE_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_o,
  input logic       strobe_o,
  input logic       blank_o,
  input logic       busy_o,
  input logic       done_o
);
  logic [7:0]  prev_ctl_q;
  logic [15:0] hold_q, hold_now;

  always_comb begin
    if (ctl_o != prev_ctl_q)   hold_now = '0;
    else if (hold_q == 16'hFFFF) hold_now = hold_q;
    else                        hold_now = hold_q + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ctl_q <= '0;
      hold_q     <= '0;
    end else begin
      prev_ctl_q <= ctl_o;
      hold_q     <= hold_now;
    end
  end

  assert_strobe_in_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> blank_o);
  assert_settle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (32'(hold_now) >= SETTLE_CYC - 1));
  assert_restore_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_o) |-> ctl_o[6]);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !blank_o && ctl_o[6]));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind synth_serial_loader ssl_checker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_o(ctl_o), .strobe_o(strobe_o),
  .blank_o(blank_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/synth_serial_loader_tb.sv
module synth_serial_loader_tb;
  localparam int SETTLE = 3;
  localparam int BLANK  = 20;
  localparam int TAIL   = 8;
  localparam int FINAL  = 12;

  logic        clk, rst_n, start_i;
  logic [4:0]  loc_i;
  logic [12:0] word_i;
  logic [7:0]  ctl_o;
  logic        strobe_o, blank_o, busy_o, done_o;

  synth_serial_loader #(.SETTLE_CYC(SETTLE), .BLANK_CYC(BLANK),
                        .TAIL_CYC(TAIL), .FINAL_CYC(FINAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .loc_i(loc_i), .word_i(word_i),
    .ctl_o(ctl_o), .strobe_o(strobe_o), .blank_o(blank_o), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed { logic [1:0] kind; logic [7:0] val; } ev_t;
  ev_t exp_q[$];
  int  n_chk = 0, n_bad = 0, n_done = 0;
  int  lat = 0;
  bit  first_pending = 0;
  logic [7:0] prev_ctl = '0;
  int  hold = 0;
  logic prev_blank = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic pop_cmp(input logic [1:0] kind, input logic [7:0] val, input string req);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, req, {22'd0, kind, val}, 0);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind && e.val == val, req, {22'd0, kind, val}, {22'd0, e.kind, e.val});
    end
  endtask

  // Monitor: compares observed strobes, restore and completion with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (ctl_o != prev_ctl) hold = 0; else hold = hold + 1;
      if (first_pending) lat = lat + 1;
      if (strobe_o) begin
        pop_cmp(2'd0, ctl_o, "R3/R4/R5 strobed value");
        check(hold >= SETTLE - 1, "R6 settle hold", hold, SETTLE - 1);
        if (first_pending) begin
          check(lat >= BLANK + SETTLE - 1, "R2 blank wait", lat, BLANK + SETTLE - 1);
          first_pending = 0;
        end
      end
      if (prev_blank && !blank_o) pop_cmp(2'd1, ctl_o, "R7/R10 restore value");
      if (done_o) begin
        pop_cmp(2'd2, ctl_o, "R8 final value");
        n_done++;
      end
      prev_ctl   = ctl_o;
      prev_blank = blank_o;
    end
  end

  task automatic run(input logic [4:0] loc, input logic [12:0] word,
                     input logic [7:0] saved, input bit poke_busy);
    logic [20:0] frame;
    int d0;
    frame = {word, loc, 3'b001};
    exp_q.push_back({2'd0, 8'h00});
    exp_q.push_back({2'd0, 8'h01});
    for (int i = 0; i < 21; i++) begin
      exp_q.push_back({2'd0, 8'h01 | ({7'd0, frame[i]} << 2)});
      exp_q.push_back({2'd0, 8'h09 | ({7'd0, frame[i]} << 2)});
    end
    exp_q.push_back({2'd1, saved | 8'h40});
    exp_q.push_back({2'd2, {4'h4, loc[3:0]}});
    d0 = n_done;
    loc_i = loc; word_i = word; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0; first_pending = 1;
    check(blank_o == 1'b1, "R2 blank set", blank_o, 1);
    check(ctl_o == 8'h00, "R2 ctl cleared", ctl_o, 0);
    check(busy_o == 1'b1, "R2 busy set", busy_o, 1);
    loc_i = ~loc; word_i = ~word;
    if (poke_busy) begin
      repeat (BLANK + 40) @(negedge clk);
      check(busy_o == 1'b1, "R9 busy during frame", busy_o, 1);
      start_i = 1'b1;               // R9: must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    while (n_done == d0) @(negedge clk);
    check(busy_o == 1'b0 && blank_o == 1'b0, "R8 idle after done", {busy_o, blank_o}, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    check(exp_q.size() == 0, "R4 all events seen", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; loc_i = '0; word_i = '0;
    fork
      begin
        repeat (3) @(negedge clk);
        check(ctl_o == 8'h00, "R1 ctl reset", ctl_o, 0);
        check({strobe_o, blank_o, busy_o, done_o} == 4'b0, "R1 flags reset",
              {strobe_o, blank_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run(5'b10110, 13'h1A5C, 8'h00, 1'b0);                 // R3 R4 R5 R7
        run(5'b01011, 13'h0F0F, {4'h4, 4'b0110}, 1'b1);       // R9 R10
        run(5'b11111, 13'h1FFF, {4'h4, 4'b1011}, 1'b0);       // R4 all ones
        run(5'b00000, 13'h0000, {4'h4, 4'b1111}, 1'b0);       // R4 all zeros, R10
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R8 watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule